// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Comparator with Lock Monitor

This block compares, for each of two synthesizer channels, a reference strobe train against a divided feedback strobe train. Both trains arrive as single-cycle strobes that are synchronous to the system clock. For each channel it produces registered up, down and drive-enable signals, which model the control of a tri-stated charge pump. A polarity input per channel exchanges the meaning of up and down, to suit the sign of the loop filter and oscillator gain. When the edges coincide, the comparator still emits a one-tick pulse on both up and down, so there is no dead zone.

A lock meter counts the phase error of every comparison cycle in system-clock ticks. The per-channel lock flag rises only after a run of consecutive small errors, and it falls on a single large error. Errors that fall between the two thresholds keep the flag as it is. A channel in power save has its drive forced off and counts as locked in the combined lock indicator. After power save or reset, a channel ignores feedback strobes until the first reference strobe. That strobe realigns the detector with a single zero-error overlap tick, which limits the disturbance on wake-up. A shared monitor output carries either the combined lock indicator or a registered copy of one of the four strobe inputs.

Top module: `dual_pfd_lock`

## Requirements
- R1: While reset is held and on the first cycles after it, up, down, drive-enable, combined lock and the monitor output are all 0.
- R2: With polarity 1, if reference leads feedback by k ticks, up is high for k+1 ticks and down is high for 1 tick, which is the overlap tick. If feedback leads, the counts are exchanged. The other channel's drive stays low.
- R3: With polarity 0, the up and down outputs are exchanged relative to R2.
- R4: Coincident reference and feedback strobes produce exactly one tick of both up and down.
- R5: Drive-enable is high exactly when up or down is high.
- R6: While a channel's power-save input is 1, its up, down and drive-enable outputs are 0 from the next cycle on, and strobes have no effect on them.
- R7: A channel's lock flag rises only after GOOD_RUNS consecutive comparisons (default 3), each with an error of at most LOCK_TICKS ticks (default 1). Two such comparisons are not enough.
- R8: One comparison with an error of UNLOCK_TICKS or more (default 3) clears the lock flag. An error strictly between the thresholds keeps the lock flag unchanged and restarts the run.
- R9: The combined lock output is 1 only when each channel is locked or in power save. Power save clears a channel's run count but keeps its lock flag.
- R10: After reset or power-save exit, feedback strobes are ignored until the first reference strobe. That strobe yields one overlap tick (one up, one down) that counts as a zero-error comparison.
- R11: With mon_sel 0, the monitor carries the combined lock. With mon_sel 1, tap_sel bit 0 picks channel B (1) or A (0) and tap_sel bit 1 picks feedback (1) or reference (0). The monitor has the same one-cycle register latency as the combined lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a | input | 1 | Channel A reference strobe |
| fb_a | input | 1 | Channel A feedback strobe |
| ref_b | input | 1 | Channel B reference strobe |
| fb_b | input | 1 | Channel B feedback strobe |
| pol_a | input | 1 | Channel A polarity (1: reference lead drives up) |
| pol_b | input | 1 | Channel B polarity |
| sleep_a | input | 1 | Channel A power save, active high |
| sleep_b | input | 1 | Channel B power save, active high |
| mon_sel | input | 1 | Monitor source: 0 lock, 1 strobe tap |
| tap_sel | input | 2 | Strobe tap choice: bit 0 channel, bit 1 feedback |
| up_a | output | 1 | Channel A up command |
| dn_a | output | 1 | Channel A down command |
| drv_a | output | 1 | Channel A drive enable (0 means undriven) |
| up_b | output | 1 | Channel B up command |
| dn_b | output | 1 | Channel B down command |
| drv_b | output | 1 | Channel B drive enable |
| lock_all | output | 1 | Combined lock indicator |
| mon_out | output | 1 | Shared monitor output |

## Verification
Four properties are checked on every clock. Drive-enable must track up or down. A channel in power save must be quiet on the cycle after power save is sampled. An awake, unlocked channel must hold the combined lock low. A monitor in lock mode must equal the combined lock. Several behaviours appear only across whole comparison sequences, so only the bench scenarios can show them. These are the pulse widths for a given lead and polarity, the three-run lock rule, the hysteresis between the thresholds, the realignment after wake-up and the strobe tap mapping.

// File: rtl/dpfd_pkg.sv
package dpfd_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic up;
    logic dn;
    logic drv;
  } drive_t;
endpackage

// File: rtl/dpfd_core.sv
// Per-channel phase-frequency state: two flags that set on strobes and
// clear together one tick after both are high. Disarmed after reset or
// power save until a reference strobe realigns it.
module dpfd_core (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  input  logic ref_stb,
  input  logic fb_stb,
  output logic up_q,
  output logic dn_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      if (ref_stb) begin
        up_q    <= 1'b1;
        dn_q    <= 1'b1;
        armed_q <= 1'b1;
      end
    end else if (up_q && dn_q) begin
      up_q <= ref_stb;
      dn_q <= fb_stb;
    end else begin
      up_q <= up_q | ref_stb;
      dn_q <= dn_q | fb_stb;
    end
  end
endmodule

// File: rtl/dpfd_lockmeter.sv
// Counts ticks with exactly one of up/down high; judges each comparison
// at its overlap tick and maintains a hysteretic lock flag.
module dpfd_lockmeter #(
  parameter int ERR_W        = 5,
  parameter int LOCK_TICKS   = 1,
  parameter int UNLOCK_TICKS = 3,
  parameter int GOOD_RUNS    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  input  logic up_q,
  input  logic dn_q,
  output logic lock_q
);
  localparam int RUN_W = $clog2(GOOD_RUNS + 1);
  localparam logic [ERR_W-1:0] ERR_MAX    = '1;
  localparam logic [ERR_W-1:0] LOCK_LIM   = ERR_W'(LOCK_TICKS);
  localparam logic [ERR_W-1:0] UNLOCK_LIM = ERR_W'(UNLOCK_TICKS);
  localparam logic [RUN_W-1:0] RUN_LAST   = RUN_W'(GOOD_RUNS - 1);

  logic [ERR_W-1:0] err_q;
  logic [RUN_W-1:0] run_q;
  logic             overlap;
  logic             lone;

  assign overlap = up_q & dn_q;
  assign lone    = up_q ^ dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (sleep) begin
      err_q <= '0;
      run_q <= '0;
    end else if (overlap) begin
      err_q <= '0;
      if (err_q >= UNLOCK_LIM) begin
        lock_q <= 1'b0;
        run_q  <= '0;
      end else if (err_q <= LOCK_LIM) begin
        if (run_q >= RUN_LAST) lock_q <= 1'b1;
        else                   run_q  <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end else if (lone && (err_q != ERR_MAX)) begin
      err_q <= err_q + 1'b1;
    end
  end
endmodule

// File: rtl/dpfd_monsel.sv
// Combines channel lock flags and selects the shared monitor source.
module dpfd_monsel
  import dpfd_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] lock_v,
  input  logic [NCH-1:0] sleep_v,
  input  logic [NCH-1:0] ref_v,
  input  logic [NCH-1:0] fb_v,
  input  logic           mon_sel,
  input  logic [1:0]     tap_sel,
  output logic           lock_all,
  output logic           mon_out
);
  logic lock_comb;
  logic tap;

  assign lock_comb = &(lock_v | sleep_v);
  assign tap       = tap_sel[1] ? fb_v[tap_sel[0]] : ref_v[tap_sel[0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_all <= 1'b0;
      mon_out  <= 1'b0;
    end else begin
      lock_all <= lock_comb;
      mon_out  <= mon_sel ? tap : lock_comb;
    end
  end
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
  import dpfd_pkg::*;
#(
  parameter int ERR_W        = 5,
  parameter int LOCK_TICKS   = 1,
  parameter int UNLOCK_TICKS = 3,
  parameter int GOOD_RUNS    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_a,
  input  logic       fb_a,
  input  logic       ref_b,
  input  logic       fb_b,
  input  logic       pol_a,
  input  logic       pol_b,
  input  logic       sleep_a,
  input  logic       sleep_b,
  input  logic       mon_sel,
  input  logic [1:0] tap_sel,
  output logic       up_a,
  output logic       dn_a,
  output logic       drv_a,
  output logic       up_b,
  output logic       dn_b,
  output logic       drv_b,
  output logic       lock_all,
  output logic       mon_out
);
  logic [NCH-1:0] ref_v, fb_v, pol_v, sleep_v;
  logic [NCH-1:0] up_raw, dn_raw;
  logic [NCH-1:0] up_o, dn_o, drv_o;
  logic [NCH-1:0] chan_lock;

  assign ref_v   = {ref_b, ref_a};
  assign fb_v    = {fb_b, fb_a};
  assign pol_v   = {pol_b, pol_a};
  assign sleep_v = {sleep_b, sleep_a};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    drive_t q;

    dpfd_core u_core (
      .clk     (clk),
      .rst     (rst),
      .sleep   (sleep_v[i]),
      .ref_stb (ref_v[i]),
      .fb_stb  (fb_v[i]),
      .up_q    (up_raw[i]),
      .dn_q    (dn_raw[i])
    );

    dpfd_lockmeter #(
      .ERR_W        (ERR_W),
      .LOCK_TICKS   (LOCK_TICKS),
      .UNLOCK_TICKS (UNLOCK_TICKS),
      .GOOD_RUNS    (GOOD_RUNS)
    ) u_meter (
      .clk    (clk),
      .rst    (rst),
      .sleep  (sleep_v[i]),
      .up_q   (up_raw[i]),
      .dn_q   (dn_raw[i]),
      .lock_q (chan_lock[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        q.up  <= !sleep_v[i] && (pol_v[i] ? up_raw[i] : dn_raw[i]);
        q.dn  <= !sleep_v[i] && (pol_v[i] ? dn_raw[i] : up_raw[i]);
        q.drv <= !sleep_v[i] && (up_raw[i] || dn_raw[i]);
      end
    end

    assign up_o[i]  = q.up;
    assign dn_o[i]  = q.dn;
    assign drv_o[i] = q.drv;
  end

  dpfd_monsel u_mon (
    .clk      (clk),
    .rst      (rst),
    .lock_v   (chan_lock),
    .sleep_v  (sleep_v),
    .ref_v    (ref_v),
    .fb_v     (fb_v),
    .mon_sel  (mon_sel),
    .tap_sel  (tap_sel),
    .lock_all (lock_all),
    .mon_out  (mon_out)
  );

  assign up_a  = up_o[0];
  assign dn_a  = dn_o[0];
  assign drv_a = drv_o[0];
  assign up_b  = up_o[1];
  assign dn_b  = dn_o[1];
  assign drv_b = drv_o[1];
endmodule

// File: rtl/dpfd_chk.sv
module dpfd_chk (
  input logic       clk,
  input logic       rst,
  input logic       sleep_a,
  input logic       sleep_b,
  input logic       mon_sel,
  input logic       up_a,
  input logic       dn_a,
  input logic       drv_a,
  input logic       up_b,
  input logic       dn_b,
  input logic       drv_b,
  input logic       lock_all,
  input logic       mon_out,
  input logic [1:0] lk
);
  p_drive_match_r5a: assert property (@(posedge clk) disable iff (rst)
    drv_a == (up_a || dn_a));
  p_drive_match_r5b: assert property (@(posedge clk) disable iff (rst)
    drv_b == (up_b || dn_b));

  p_sleep_quiet_r6a: assert property (@(posedge clk) disable iff (rst)
    $past(sleep_a) |-> !(up_a || dn_a || drv_a));
  p_sleep_quiet_r6b: assert property (@(posedge clk) disable iff (rst)
    $past(sleep_b) |-> !(up_b || dn_b || drv_b));

  p_unlock_all_r9a: assert property (@(posedge clk) disable iff (rst)
    ($past(!sleep_a) && $past(!lk[0])) |-> !lock_all);
  p_unlock_all_r9b: assert property (@(posedge clk) disable iff (rst)
    ($past(!sleep_b) && $past(!lk[1])) |-> !lock_all);

  p_mon_lock_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!mon_sel) |-> (mon_out == lock_all));
endmodule

bind dual_pfd_lock dpfd_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sleep_a  (sleep_a),
  .sleep_b  (sleep_b),
  .mon_sel  (mon_sel),
  .up_a     (up_a),
  .dn_a     (dn_a),
  .drv_a    (drv_a),
  .up_b     (up_b),
  .dn_b     (dn_b),
  .drv_b    (drv_b),
  .lock_all (lock_all),
  .mon_out  (mon_out),
  .lk       (chan_lock)
);

// File: tb/tb_dual_pfd_lock.sv
`timescale 1ns/1ps
module tb_dual_pfd_lock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_a = 0, fb_a = 0, ref_b = 0, fb_b = 0;
  logic pol_a = 1, pol_b = 1, sleep_a = 0, sleep_b = 0;
  logic mon_sel = 0;
  logic [1:0] tap_sel = 2'b00;
  logic up_a, dn_a, drv_a, up_b, dn_b, drv_b, lock_all, mon_out;

  always #4 clk = ~clk;

  dual_pfd_lock dut (
    .clk(clk), .rst(rst), .ref_a(ref_a), .fb_a(fb_a), .ref_b(ref_b), .fb_b(fb_b),
    .pol_a(pol_a), .pol_b(pol_b), .sleep_a(sleep_a), .sleep_b(sleep_b),
    .mon_sel(mon_sel), .tap_sel(tap_sel),
    .up_a(up_a), .dn_a(dn_a), .drv_a(drv_a), .up_b(up_b), .dn_b(dn_b), .drv_b(drv_b),
    .lock_all(lock_all), .mon_out(mon_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  int c_up[2], c_dn[2], c_drv[2];
  int c_mon;

  // {channel, polarity, reference leads, lead in ticks}
  localparam logic [7:0] VEC [9] = '{
    8'h60, 8'h62, 8'h44, 8'h23, 8'h01, 8'hE5, 8'h82, 8'hC0, 8'h67
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 2; i++) begin
      c_up[i] = 0; c_dn[i] = 0; c_drv[i] = 0;
    end
    c_mon = 0;
  endtask

  task automatic cyc(input logic ra, input logic fa, input logic rb, input logic fbb);
    @(negedge clk);
    c_up[0]  += int'(up_a);  c_dn[0] += int'(dn_a);  c_drv[0] += int'(drv_a);
    c_up[1]  += int'(up_b);  c_dn[1] += int'(dn_b);  c_drv[1] += int'(drv_b);
    c_mon    += int'(mon_out);
    ref_a = ra; fb_a = fa; ref_b = rb; fb_b = fbb;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic pair(input int ch, input bit lr, input int k);
    for (int i = 0; i <= k; i++) begin
      logic r, f;
      r = lr ? (i == 0) : (i == k);
      f = lr ? (i == k) : (i == 0);
      if (ch == 0) cyc(r, f, 1'b0, 1'b0);
      else         cyc(1'b0, 1'b0, r, f);
    end
    idle(8);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    clr();
    idle(3);
    chk("R1 drv_a in reset", int'(drv_a), 0);
    rst = 1'b0;
    idle(2);
    chk("R1 up_a", int'(up_a), 0);
    chk("R1 dn_b", int'(dn_b), 0);
    chk("R1 lock_all", int'(lock_all), 0);
    chk("R1 mon_out", int'(mon_out), 0);

    // Both asleep: counted as locked, outputs quiet.
    sleep_a = 1; sleep_b = 1;
    idle(3);
    chk("R9 both asleep lock", int'(lock_all), 1);
    clr();
    pair(0, 1'b1, 3);
    chk("R6 up_a asleep", c_up[0], 0);
    chk("R6 dn_a asleep", c_dn[0], 0);
    chk("R6 drv_a asleep", c_drv[0], 0);

    sleep_a = 0; sleep_b = 0;
    idle(2);
    chk("R9 awake unlocked", int'(lock_all), 0);
    clr();
    pair(0, 1'b1, 0);
    pair(1, 1'b1, 0);
    chk("R10 prime A up", c_up[0], 1);
    chk("R10 prime B dn", c_dn[1], 1);

    // Table of comparisons: lead, polarity and channel.
    for (int v = 0; v < 9; v++) begin
      int ch, k, e_up, e_dn;
      bit pol, lr;
      ch  = int'(VEC[v][7]);
      pol = VEC[v][6];
      lr  = VEC[v][5];
      k   = int'(VEC[v][4:0]);
      if (ch == 0) pol_a = pol; else pol_b = pol;
      idle(1);
      clr();
      pair(ch, lr, k);
      e_up = (lr == pol) ? k + 1 : 1;
      e_dn = (lr == pol) ? 1 : k + 1;
      chk(pol ? "R2 up width" : "R3 up width", c_up[ch], e_up);
      chk(pol ? "R2 dn width" : "R3 dn width", c_dn[ch], e_dn);
      chk(k == 0 ? "R4 drive width" : "R5 drive width", c_drv[ch], k + 1);
      chk("R2 other channel idle", c_drv[1 - ch], 0);
    end

    // Lock hysteresis on A with B asleep.
    pol_a = 1; sleep_b = 1;
    pair(0, 1'b1, 5);
    pair(0, 1'b1, 0);
    pair(0, 1'b1, 0);
    chk("R7 two good runs", int'(lock_all), 0);
    pair(0, 1'b1, 1);
    chk("R7 third good run", int'(lock_all), 1);
    pair(0, 1'b1, 2);
    chk("R8 middle error holds", int'(lock_all), 1);
    pair(0, 1'b1, 3);
    chk("R8 large error drops", int'(lock_all), 0);
    pair(0, 1'b1, 0);
    pair(0, 1'b1, 0);
    pair(0, 1'b1, 0);
    chk("R9 A locked B asleep", int'(lock_all), 1);

    // Wake B: unlocked, realign ignores early feedback.
    sleep_b = 0; pol_b = 1;
    idle(2);
    chk("R9 B awake unlocked", int'(lock_all), 0);
    clr();
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    idle(3);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    idle(3);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    idle(8);
    chk("R10 realign up", c_up[1], 1);
    chk("R10 realign dn", c_dn[1], 1);
    pair(1, 1'b1, 0);
    chk("R7 B two runs", int'(lock_all), 0);
    pair(1, 1'b1, 0);
    chk("R9 both locked", int'(lock_all), 1);

    // Monitor.
    mon_sel = 0;
    idle(2);
    chk("R11 monitor lock", int'(mon_out), int'(lock_all));
    mon_sel = 1;
    for (int t = 0; t < 4; t++) begin
      tap_sel = 2'(t);
      idle(2);
      clr();
      cyc(1'b1, 1'b0, 1'b0, 1'b0); idle(2);
      repeat (2) begin cyc(1'b0, 1'b0, 1'b1, 1'b0); idle(2); end
      repeat (3) begin cyc(1'b0, 1'b1, 1'b0, 1'b0); idle(2); end
      repeat (4) begin cyc(1'b0, 1'b0, 1'b0, 1'b1); idle(2); end
      idle(3);
      chk("R11 tap count", c_mon, t + 1);
    end

    summary();
    $finish;
  end
endmodule